// File: doc/BRIEF.md
# Replay-Driven Issue Throttle for Two Tag Banks

This block sits beside a pair of cache tag banks and decides, every cycle, whether each bank may accept a new request. Each bank reports three events per cycle: a request was issued to it, a transaction on it was replayed, or a transaction on it passed its hazard check and completed. The block keeps, for each bank, a count of back-to-back replays and a count of requests still in flight.

A bank whose replay count climbs to the threshold (32 by default) is considered congested. Depending on configuration, a congested bank is cut down to one request at a time, or the whole pair is cut down to one request across both banks. Either restriction lasts until a transaction on the congested bank passes its hazard check. A separate static setting limits every bank to one outstanding request, whatever its replay history. With every setting off, which is the reset state, both banks take requests in parallel.

All outputs are combinational functions of registered state and the static configuration inputs. An event sampled at one clock edge shows on the issue-allow outputs right after that edge.

Top module: `replay_issue_ctrl`

## Requirements
- R1: With all three configuration inputs low, `issue_allow` is all ones, whatever the traffic and replay counts. An asserted `rst_n` clears every replay count and every in-flight count at once.
- R2: Each bank has its own replay count. A `bank_replay` pulse raises that bank's count by one. A `bank_pass` pulse clears it to zero. When both arrive in the same cycle, the pass wins and the count becomes zero. Events on one bank never change the other bank's count.
- R3: A replay count stops at the threshold (default 32). Further replays leave it at the threshold and never wrap.
- R4: When `cfg_bank_single` is high and `cfg_cross_single` is low, a bank whose count equals the threshold has `issue_allow` low while its in-flight count is nonzero, and high while it is zero. Below the threshold the bank is not restricted.
- R5: The restriction from R4 or R6 ends only when a pass on the congested bank clears its count. The next cycle the bank is unrestricted even if other requests are still in flight.
- R6: When `cfg_cross_single` is high and at least one bank's count equals the threshold, at most one `issue_allow` bit is high. That bit belongs to the lowest-numbered bank at the threshold, and it is high only when no bank has a request in flight.
- R7: When `cfg_one_per_bank` is high and R6 is not active, each bank's `issue_allow` is low exactly while that bank's in-flight count is nonzero, independent of its replay count.
- R8: A `bank_issue` pulse raises a bank's in-flight count by one. A `bank_pass` pulse lowers it by one, never below zero. A restricted bank's `issue_allow` rises in the cycle right after the pass that empties it.
- R9: Reaching the threshold has no effect on `issue_allow` while `cfg_bank_single` and `cfg_cross_single` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_one_per_bank | input | 1 | Static limit of one outstanding request per bank |
| cfg_bank_single | input | 1 | Single issue on a bank whose replay count reached the threshold |
| cfg_cross_single | input | 1 | Single issue across all banks once any bank reaches the threshold |
| bank_issue | input | NUM_BANKS | Per-bank pulse: a request was issued this cycle |
| bank_replay | input | NUM_BANKS | Per-bank pulse: a transaction was replayed this cycle |
| bank_pass | input | NUM_BANKS | Per-bank pulse: a transaction passed hazard checking this cycle |
| issue_allow | output | NUM_BANKS | Per-bank permission to issue a new request |

## Verification
A vector table covers plain parallel traffic and the static one-per-bank limit. Issues and passes are interleaved on both banks, so that a limit applied to the wrong bank, or released one cycle late, shows up on a single bit. Directed runs then replay a bank 31 and 32 times, which separates the threshold from its neighbour, and go on to 40 replays to expose a counter that wraps. They also send a pass while two requests are still in flight, which shows that leaving the restricted mode depends on the pass and not on draining. Both banks are driven to the threshold in cross-bank mode, which checks which bank is granted. A replay and a pass in the same cycle on a saturated bank tells a clear-first counter from a count-first one.

// File: rtl/rsi_pkg.sv
package rsi_pkg;

  // Static throttle configuration, gathered from the top-level pins.
  typedef struct packed {
    logic cross_single;
    logic bank_single;
    logic one_per_bank;
  } rsi_cfg_t;

endpackage

// File: rtl/rsi_rst_sync.sv
module rsi_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  // Asynchronous assertion, synchronous release through a shift chain.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/rsi_replay_cnt.sv
module rsi_replay_cnt #(
  parameter int LIMIT = 32,
  parameter int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             replay_i,
  input  logic             pass_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CAP = CNT_W'(LIMIT);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  // Next state: a pass clears first, a replay counts only below the cap.
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (pass_i) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (replay_i && (cnt_q != CAP)) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rsi_inflight.sv
module rsi_inflight #(
  parameter int MAX_INFLIGHT = 15,
  parameter int INF_W        = $clog2(MAX_INFLIGHT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic             done_i,
  output logic [INF_W-1:0] cnt_o
);

  localparam logic [INF_W-1:0] TOP = INF_W'(MAX_INFLIGHT);

  logic [INF_W-1:0] cnt_q;
  logic [INF_W-1:0] cnt_d;
  logic             cnt_en;
  logic             up;
  logic             dn;

  assign up = issue_i && !done_i && (cnt_q != TOP);
  assign dn = done_i && !issue_i && (cnt_q != '0);

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (up) begin
      cnt_d  = cnt_q + 1'b1;
      cnt_en = 1'b1;
    end else if (dn) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/rsi_issue_gate.sv
module rsi_issue_gate
  import rsi_pkg::*;
#(
  parameter int NB = 2
) (
  input  rsi_cfg_t        cfg_i,
  input  logic [NB-1:0]   at_limit_i,
  input  logic [NB-1:0]   busy_i,
  output logic [NB-1:0]   allow_o
);

  logic [NB-1:0] first_hot;
  logic [NB-1:0] local_hold;
  logic          cross_mode;
  logic          all_idle;

  // Lowest-numbered bank sitting at the threshold.
  always_comb begin
    logic found;
    found     = 1'b0;
    first_hot = '0;
    for (int b = 0; b < NB; b++) begin
      if (at_limit_i[b] && !found) begin
        first_hot[b] = 1'b1;
        found        = 1'b1;
      end
    end
  end

  assign cross_mode = cfg_i.cross_single && (|at_limit_i);
  assign all_idle   = ~(|busy_i);

  for (genvar b = 0; b < NB; b++) begin : g_gate
    assign local_hold[b] = busy_i[b] &&
                           (cfg_i.one_per_bank || (cfg_i.bank_single && at_limit_i[b]));
    assign allow_o[b]    = cross_mode ? (first_hot[b] && all_idle) : !local_hold[b];
  end

endmodule

// File: rtl/replay_issue_ctrl.sv
module replay_issue_ctrl
  import rsi_pkg::*;
#(
  parameter int NUM_BANKS    = 2,
  parameter int REPLAY_LIMIT = 32,
  parameter int MAX_INFLIGHT = 15
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_one_per_bank,
  input  logic                 cfg_bank_single,
  input  logic                 cfg_cross_single,
  input  logic [NUM_BANKS-1:0] bank_issue,
  input  logic [NUM_BANKS-1:0] bank_replay,
  input  logic [NUM_BANKS-1:0] bank_pass,
  output logic [NUM_BANKS-1:0] issue_allow
);

  localparam int CNT_W = $clog2(REPLAY_LIMIT + 1);
  localparam int INF_W = $clog2(MAX_INFLIGHT + 1);
  localparam logic [CNT_W-1:0] CAP = CNT_W'(REPLAY_LIMIT);

  logic                              rst_sync_n;
  rsi_cfg_t                          cfg;
  logic [NUM_BANKS-1:0][CNT_W-1:0]   rc_cnt;
  logic [NUM_BANKS-1:0][INF_W-1:0]   fl_cnt;
  logic [NUM_BANKS-1:0]              at_limit;
  logic [NUM_BANKS-1:0]              busy;

  assign cfg.cross_single = cfg_cross_single;
  assign cfg.bank_single  = cfg_bank_single;
  assign cfg.one_per_bank = cfg_one_per_bank;

  rsi_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    rsi_replay_cnt #(.LIMIT(REPLAY_LIMIT), .CNT_W(CNT_W)) u_rc (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .replay_i (bank_replay[b]),
      .pass_i   (bank_pass[b]),
      .cnt_o    (rc_cnt[b])
    );

    rsi_inflight #(.MAX_INFLIGHT(MAX_INFLIGHT), .INF_W(INF_W)) u_fl (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .issue_i (bank_issue[b]),
      .done_i  (bank_pass[b]),
      .cnt_o   (fl_cnt[b])
    );

    assign at_limit[b] = (rc_cnt[b] == CAP);
    assign busy[b]     = (fl_cnt[b] != '0);
  end

  rsi_issue_gate #(.NB(NUM_BANKS)) u_gate (
    .cfg_i      (cfg),
    .at_limit_i (at_limit),
    .busy_i     (busy),
    .allow_o    (issue_allow)
  );

endmodule

// File: rtl/rsi_chk.sv
module rsi_chk #(
  parameter int NB           = 2,
  parameter int LIMIT        = 32,
  parameter int MAX_INFLIGHT = 15,
  parameter int CNT_W        = 6,
  parameter int INF_W        = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cfg_one_per_bank,
  input logic                       cfg_bank_single,
  input logic                       cfg_cross_single,
  input logic [NB-1:0]              bank_issue,
  input logic [NB-1:0]              bank_replay,
  input logic [NB-1:0]              bank_pass,
  input logic [NB-1:0]              issue_allow,
  input logic [NB-1:0][CNT_W-1:0]   cnt,
  input logic [NB-1:0][INF_W-1:0]   infl
);

  logic [NB-1:0] hit;
  logic          cross_on;

  for (genvar b = 0; b < NB; b++) begin : g_hit
    assign hit[b] = (cnt[b] == CNT_W'(LIMIT));
  end
  assign cross_on = cfg_cross_single && (hit != '0);

  AST_OPEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_one_per_bank && !cfg_bank_single && !cfg_cross_single) |-> (issue_allow == {NB{1'b1}})); // R1

  AST_CROSS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    cross_on |-> $onehot0(issue_allow)); // R6

  for (genvar b = 0; b < NB; b++) begin : g_bank_chk
    AST_PASS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      bank_pass[b] |=> (cnt[b] == '0)); // R2

    AST_REPLAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_replay[b] && !bank_pass[b] && (cnt[b] < CNT_W'(LIMIT)))
        |=> (cnt[b] == $past(cnt[b]) + 1'b1)); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_replay[b] && !bank_pass[b] && hit[b]) |=> hit[b]); // R3

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[b] <= CNT_W'(LIMIT)); // R3

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_bank_single && !cross_on && hit[b] && (infl[b] != '0)) |-> !issue_allow[b]); // R4

    AST_STATIC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_one_per_bank && !cross_on && (infl[b] != '0)) |-> !issue_allow[b]); // R7

    AST_INFL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (bank_issue[b] && !bank_pass[b] && (infl[b] != INF_W'(MAX_INFLIGHT)))
        |=> (infl[b] == $past(infl[b]) + 1'b1)); // R8
  end

endmodule

bind replay_issue_ctrl rsi_chk #(
  .NB           (NUM_BANKS),
  .LIMIT        (REPLAY_LIMIT),
  .MAX_INFLIGHT (MAX_INFLIGHT),
  .CNT_W        (CNT_W),
  .INF_W        (INF_W)
) u_chk (
  .clk              (clk),
  .rst_n            (rst_sync_n),
  .cfg_one_per_bank (cfg_one_per_bank),
  .cfg_bank_single  (cfg_bank_single),
  .cfg_cross_single (cfg_cross_single),
  .bank_issue       (bank_issue),
  .bank_replay      (bank_replay),
  .bank_pass        (bank_pass),
  .issue_allow      (issue_allow),
  .cnt              (rc_cnt),
  .infl             (fl_cnt)
);

// File: tb/sim_replay_issue_ctrl.sv
`timescale 1ns/1ps
module sim_replay_issue_ctrl;

  logic       clk;
  logic       rst_n;
  logic       cfg_one, cfg_bank, cfg_cross;
  logic [1:0] iss, rep, pas;
  logic [1:0] allow;
  int         nchk;
  int         nerr;
  logic       done;

  replay_issue_ctrl u0 (
    .clk              (clk),
    .rst_n            (rst_n),
    .cfg_one_per_bank (cfg_one),
    .cfg_bank_single  (cfg_bank),
    .cfg_cross_single (cfg_cross),
    .bank_issue       (iss),
    .bank_replay      (rep),
    .bank_pass        (pas),
    .issue_allow      (allow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Vector fields: {cfg{cross,bank,one}, issue, replay, pass, expected allow}
  localparam logic [10:0] VEC [0:8] = '{
    {3'b000, 2'b11, 2'b00, 2'b00, 2'b11},
    {3'b000, 2'b00, 2'b00, 2'b11, 2'b11},
    {3'b001, 2'b01, 2'b00, 2'b00, 2'b10},
    {3'b001, 2'b10, 2'b00, 2'b00, 2'b00},
    {3'b001, 2'b00, 2'b00, 2'b01, 2'b01},
    {3'b001, 2'b00, 2'b10, 2'b00, 2'b01},
    {3'b001, 2'b00, 2'b00, 2'b10, 2'b11},
    {3'b000, 2'b01, 2'b00, 2'b00, 2'b11},
    {3'b000, 2'b00, 2'b00, 2'b01, 2'b11}
  };

  // Drive one cycle at a falling edge; return at the next falling edge.
  task automatic drive(input logic [2:0] c, input logic [1:0] i, input logic [1:0] r,
                       input logic [1:0] p);
    {cfg_cross, cfg_bank, cfg_one} = c;
    iss = i;
    rep = r;
    pas = p;
    @(negedge clk);
    iss = '0;
    rep = '0;
    pas = '0;
  endtask

  task automatic burst(input logic [2:0] c, input logic [1:0] r, input int n);
    for (int k = 0; k < n; k++) drive(c, 2'b00, r, 2'b00);
  endtask

  task automatic check(input string tag, input logic [1:0] exp);
    nchk++;
    if (allow !== exp) begin
      nerr++;
      $display("FAIL %s: issue_allow=%b expected %b", tag, allow, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    done = 1'b0;
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nerr++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    nchk = 0;
    nerr = 0;
    rst_n = 1'b0;
    {cfg_cross, cfg_bank, cfg_one} = 3'b000;
    iss = '0; rep = '0; pas = '0;
    repeat (3) @(negedge clk);
    check("R1 reset open", 2'b11);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", 2'b11);

    // Vector table: parallel traffic, static limit, in-flight release (R7, R8)
    for (int v = 0; v < 9; v++) begin
      drive(VEC[v][10:8], VEC[v][7:6], VEC[v][5:4], VEC[v][3:2]);
      check($sformatf("R7 R8 vector %0d", v), VEC[v][1:0]);
    end

    // R9: threshold reached with single-issue controls off
    burst(3'b000, 2'b01, 40);
    drive(3'b000, 2'b01, 2'b00, 2'b00);
    check("R9 threshold ignored when disabled", 2'b11);
    drive(3'b000, 2'b00, 2'b00, 2'b01);
    check("R9 drain", 2'b11);

    // R2/R3/R4/R5: per-bank single issue
    drive(3'b010, 2'b01, 2'b00, 2'b00);
    drive(3'b010, 2'b01, 2'b00, 2'b00);
    check("R4 below threshold open", 2'b11);
    burst(3'b010, 2'b01, 31);
    check("R2 31 replays no trip", 2'b11);
    drive(3'b010, 2'b00, 2'b01, 2'b00);
    check("R4 bank0 held R2 bank1 independent", 2'b10);
    burst(3'b010, 2'b01, 8);
    check("R3 saturated no wrap", 2'b10);
    drive(3'b010, 2'b00, 2'b00, 2'b01);
    check("R5 pass ends mode with one in flight", 2'b11);
    burst(3'b010, 2'b01, 32);
    check("R4 retrip held", 2'b10);
    drive(3'b010, 2'b00, 2'b00, 2'b01);
    check("R8 reassert after last pass", 2'b11);

    burst(3'b010, 2'b10, 32);
    check("R4 idle admits one", 2'b11);
    drive(3'b010, 2'b10, 2'b00, 2'b00);
    check("R4 bank1 held", 2'b01);
    drive(3'b010, 2'b00, 2'b00, 2'b10);
    check("R8 bank1 reassert", 2'b11);

    // R2 priority: pass beats replay in the same cycle
    drive(3'b010, 2'b01, 2'b00, 2'b00);
    drive(3'b010, 2'b01, 2'b00, 2'b00);
    burst(3'b010, 2'b01, 32);
    check("R4 bank0 held before tie", 2'b10);
    drive(3'b010, 2'b00, 2'b01, 2'b01);
    check("R2 pass wins over replay", 2'b11);
    drive(3'b010, 2'b00, 2'b00, 2'b01);
    check("R8 drain bank0", 2'b11);

    // R6: single issue across both banks
    burst(3'b100, 2'b10, 32);
    check("R6 only tripped bank", 2'b10);
    burst(3'b100, 2'b01, 32);
    check("R6 lowest index wins", 2'b01);
    drive(3'b100, 2'b01, 2'b00, 2'b00);
    check("R6 one across banks", 2'b00);
    drive(3'b100, 2'b00, 2'b00, 2'b01);
    check("R5 bank0 cleared bank1 remains", 2'b10);
    drive(3'b100, 2'b00, 2'b00, 2'b10);
    check("R5 R6 all cleared", 2'b11);

    // R1: asynchronous reset mid-operation
    burst(3'b010, 2'b10, 32);
    drive(3'b010, 2'b10, 2'b00, 2'b00);
    check("R4 held before reset", 2'b01);
    #1 rst_n = 1'b0;
    #1 check("R1 async clear", 2'b11);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    drive(3'b010, 2'b10, 2'b00, 2'b00);
    check("R1 counts cleared by reset", 2'b11);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule